// File: doc/BRIEF.md
# Tiled Address Bit-6 Swizzle Unit

This unit sits on the path of tiled surface accesses. It rewrites each byte address so that it lands on the same memory channel as the interleaved DRAM controller expects. Only address bit 6 changes. It is replaced by its XOR with a subset of bits 9, 10, 11 and 17. The subset comes from a 3-bit swizzle code held for each tiling layout.

Each request carries an address, a tiling layout and a row pitch (stride). The unit returns four things with the translated address:
- the tiling layout that actually applies;
- the swizzle code that software may be shown;
- the stride that applies;
- a flag that is set when a tiled request had to fall back to linear because the swizzle behaviour is unknown.

The request side and the result side are valid/ready streams. A result is registered one cycle after acceptance. While a result waits with `res_ready` low, it holds still and `req_ready` stays low, so the unit never holds more than one result. The two swizzle codes are loaded through a plain write port.

Top module: `addr_bit6_swizzle`

## Requirements
- R1: After reset `res_valid` is 0, `req_ready` is 1, and both swizzle-code registers hold code 5 (unknown). A tiled request sent before any configuration therefore falls back to linear.
- R2: Layout codes are 0 linear, 1 X-tiled, 2 Y-tiled and 3 reserved (treated as linear). A linear or reserved request returns the address unchanged, with layout 0, code 0, stride 0 and fallback 0, whatever the registers hold.
- R3: A write with `cfg_we`=1 loads `cfg_code` into the X register when `cfg_sel`=0 and into the Y register when `cfg_sel`=1. X-tiled requests use the X register and Y-tiled requests use the Y register.
- R4: For a tiled request, output bit 6 is input bit 6 XOR the bits named by the code: 0 none, 1 {9}, 2 {9,10}, 3 {9,11}, 4 {9,10,11}, 6 {9,17}, 7 {9,10,17}.
- R5: Every output address bit other than bit 6 equals the matching input bit.
- R6: The reported code for a tiled request equals the register code, except that code 6 is reported as 1 and code 7 is reported as 2. Codes 5, 6 and 7 never appear on `res_swz`.
- R7: A tiled request whose register holds code 5 returns the address unchanged, layout 0, code 0, stride 0 and `res_fallback`=1.
- R8: A request accepted at a clock edge shows its result with `res_valid`=1 right after that edge.
- R9: `req_ready` = !`res_valid` | `res_ready`. While `res_valid`=1 and `res_ready`=0, the result outputs stay unchanged on the next cycle.
- R10: A tiled request that does not fall back returns its stride unchanged and reports its own layout code.
- R11: A configuration write becomes visible to requests accepted after its edge. A request accepted at the same edge as the write uses the old code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Swizzle-code write strobe |
| cfg_sel | input | 1 | Selects the register to write: 0 X, 1 Y |
| cfg_code | input | 3 | Swizzle code to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_tile | input | 2 | Tiling layout code |
| req_stride | input | STRIDE_W | Row pitch |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_addr | output | ADDR_W | Swizzled address |
| res_tile | output | 2 | Layout that applies |
| res_swz | output | 3 | Swizzle code visible to software |
| res_stride | output | STRIDE_W | Stride that applies |
| res_fallback | output | 1 | Tiled request forced to linear |

## Verification
The bench uses the defaults: ADDR_W=32 and STRIDE_W=16. With a 32-bit address, bit 17 and the bits above the taps (up to bit 31) can be driven, so a wrong tap or a leak into a pass-through bit shows up. Every code from 0 to 7 is loaded into both registers and swept over a set of addresses that isolate each tap. One phase applies random back-pressure on the result side to exercise the holding rules. Another phase writes a register at the same edge as a request to check that the old code is used.

// File: rtl/swz_pkg.sv
package swz_pkg;

  typedef enum logic [1:0] {
    TILE_LIN = 2'd0,
    TILE_X   = 2'd1,
    TILE_Y   = 2'd2,
    TILE_RSV = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    SWZ_NONE      = 3'd0,
    SWZ_B9        = 3'd1,
    SWZ_B9_10     = 3'd2,
    SWZ_B9_11     = 3'd3,
    SWZ_B9_10_11  = 3'd4,
    SWZ_UNKNOWN   = 3'd5,
    SWZ_B9_17     = 3'd6,
    SWZ_B9_10_17  = 3'd7
  } swz_e;

  // Address bits that may be folded into bit 6; mask bit t selects TAP_POS[t].
  localparam int NUM_TAPS = 4;
  localparam int TAP_POS [NUM_TAPS] = '{9, 10, 11, 17};
  localparam int SWZ_BIT = 6;
  localparam int MIN_ADDR_W = 18;

  function automatic logic [NUM_TAPS-1:0] tap_mask(swz_e m);
    case (m)
      SWZ_B9:        tap_mask = 4'b0001;
      SWZ_B9_10:     tap_mask = 4'b0011;
      SWZ_B9_11:     tap_mask = 4'b0101;
      SWZ_B9_10_11:  tap_mask = 4'b0111;
      SWZ_B9_17:     tap_mask = 4'b1001;
      SWZ_B9_10_17:  tap_mask = 4'b1011;
      default:       tap_mask = 4'b0000;
    endcase
  endfunction

  // Bit 17 folding stays hidden from software.
  function automatic swz_e visible_code(swz_e m);
    case (m)
      SWZ_B9_17:    visible_code = SWZ_B9;
      SWZ_B9_10_17: visible_code = SWZ_B9_10;
      default:      visible_code = m;
    endcase
  endfunction

endpackage

// File: rtl/swz_mode_regs.sv
module swz_mode_regs
  import swz_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [2:0] cfg_code,
  output swz_e       mode_x,
  output swz_e       mode_y
);

  localparam int NUM_REGS = 2;

  swz_e mode_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        mode_q[r] <= SWZ_UNKNOWN;
      else if (cfg_we && (int'(cfg_sel) == r))
        mode_q[r] <= swz_e'(cfg_code);
    end
  end

  assign mode_x = mode_q[0];
  assign mode_y = mode_q[1];

  // R3 / R11: a write lands in exactly the selected register
  assert_cfg_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (mode_x == swz_e'($past(cfg_code))));
  assert_cfg_y_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (mode_y == swz_e'($past(cfg_code))));
  assert_cfg_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(mode_x) && $stable(mode_y)));

endmodule

// File: rtl/swz_xlate.sv
module swz_xlate
  import swz_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
)(
  input  logic [ADDR_W-1:0]   in_addr,
  input  logic [1:0]          in_tile,
  input  logic [STRIDE_W-1:0] in_stride,
  input  swz_e                mode_x,
  input  swz_e                mode_y,
  output logic [ADDR_W-1:0]   xl_addr,
  output logic [1:0]          xl_tile,
  output logic [2:0]          xl_swz,
  output logic [STRIDE_W-1:0] xl_stride,
  output logic                xl_fallback
);

  logic [NUM_TAPS-1:0] tap_bits;
  logic [NUM_TAPS-1:0] mask;
  swz_e                sel_mode;
  tile_e               tile;
  logic                tiled;
  logic                active;
  logic                fold;

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    assign tap_bits[t] = in_addr[TAP_POS[t]];
  end

  always_comb begin
    tile        = tile_e'(in_tile);
    tiled       = (tile == TILE_X) || (tile == TILE_Y);
    sel_mode    = (tile == TILE_Y) ? mode_y : mode_x;
    xl_fallback = tiled && (sel_mode == SWZ_UNKNOWN);
    active      = tiled && !xl_fallback;
    mask        = active ? tap_mask(sel_mode) : '0;
    fold        = ^(mask & tap_bits);
    xl_addr           = in_addr;
    xl_addr[SWZ_BIT]  = in_addr[SWZ_BIT] ^ fold;
    xl_tile     = active ? in_tile : 2'(TILE_LIN);
    xl_swz      = active ? 3'(visible_code(sel_mode)) : 3'(SWZ_NONE);
    xl_stride   = active ? in_stride : '0;
  end

endmodule

// File: rtl/swz_out_stage.sv
module swz_out_stage #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_data  = d_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      v_q <= 1'b0;
    else if (in_ready)
      v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid)
      d_q <= in_data;
  end

  // R8: accepted item is presented after one edge
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  // R9: stalled result stays put
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/addr_bit6_swizzle.sv
module addr_bit6_swizzle
  import swz_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int STRIDE_W = 16
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [2:0]          cfg_code,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_tile,
  input  logic [STRIDE_W-1:0] req_stride,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [ADDR_W-1:0]   res_addr,
  output logic [1:0]          res_tile,
  output logic [2:0]          res_swz,
  output logic [STRIDE_W-1:0] res_stride,
  output logic                res_fallback
);

  localparam int PAY_W = ADDR_W + 2 + 3 + STRIDE_W + 1;
  localparam logic [ADDR_W-1:0] KEEP_MASK = ~(ADDR_W'(1) << SWZ_BIT);

  if (ADDR_W < MIN_ADDR_W) begin : g_bad_width
    addr_width_too_small_for_bit17_tap u_stop ();
  end

  swz_e                mode_x, mode_y;
  logic [ADDR_W-1:0]   xl_addr;
  logic [1:0]          xl_tile;
  logic [2:0]          xl_swz;
  logic [STRIDE_W-1:0] xl_stride;
  logic                xl_fallback;
  logic [PAY_W-1:0]    pay_in, pay_out;

  swz_mode_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_code (cfg_code),
    .mode_x   (mode_x),
    .mode_y   (mode_y)
  );

  swz_xlate #(.ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)) u_xlate (
    .in_addr     (req_addr),
    .in_tile     (req_tile),
    .in_stride   (req_stride),
    .mode_x      (mode_x),
    .mode_y      (mode_y),
    .xl_addr     (xl_addr),
    .xl_tile     (xl_tile),
    .xl_swz      (xl_swz),
    .xl_stride   (xl_stride),
    .xl_fallback (xl_fallback)
  );

  assign pay_in = {xl_addr, xl_tile, xl_swz, xl_stride, xl_fallback};

  swz_out_stage #(.W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (pay_out)
  );

  assign {res_addr, res_tile, res_swz, res_stride, res_fallback} = pay_out;

  // R5: only bit 6 may differ from the accepted address
  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ((res_addr & KEEP_MASK) == ($past(req_addr) & KEEP_MASK)));
  // R6: hidden codes never reach software
  assert_visible_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_swz <= 3'd4));
  // R7: fallback result is fully linear
  assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fallback) |-> (res_tile == 2'd0 && res_swz == 3'd0 &&
                                     res_stride == '0));
  // R2: a non-tiled request never falls back and reports linear
  assert_linear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_tile == 2'd0 || req_tile == 2'd3))
      |=> (!res_fallback && res_tile == 2'd0 && res_swz == 3'd0));

endmodule

// File: tb/addr_bit6_swizzle_tb.sv
module addr_bit6_swizzle_tb;

  localparam int AW = 32;
  localparam int SW = 16;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    tile;
    logic [2:0]    swz;
    logic [SW-1:0] stride;
    logic          fb;
    string         tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cfg_we = 0, cfg_sel = 0;
  logic [2:0]    cfg_code = 0;
  logic          req_valid = 0;
  logic          req_ready;
  logic [AW-1:0] req_addr = 0;
  logic [1:0]    req_tile = 0;
  logic [SW-1:0] req_stride = 0;
  logic          res_valid;
  logic          res_ready = 1;
  logic [AW-1:0] res_addr;
  logic [1:0]    res_tile;
  logic [2:0]    res_swz;
  logic [SW-1:0] res_stride;
  logic          res_fallback;

  int   errors = 0;
  int   checks = 0;
  int   cycles = 0;
  bit   bp_en = 0;
  bit   done = 0;
  logic [2:0] mdl_x = 3'd5, mdl_y = 3'd5;
  exp_t sb [$];

  always #4 clk = ~clk;

  addr_bit6_swizzle #(.ADDR_W(AW), .STRIDE_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_code(cfg_code),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_tile(req_tile), .req_stride(req_stride), .res_valid(res_valid),
    .res_ready(res_ready), .res_addr(res_addr), .res_tile(res_tile),
    .res_swz(res_swz), .res_stride(res_stride), .res_fallback(res_fallback)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic fold_bit(logic [2:0] code, logic [AW-1:0] a);
    case (code)
      3'd1: return a[9];
      3'd2: return a[9] ^ a[10];
      3'd3: return a[9] ^ a[11];
      3'd4: return a[9] ^ a[10] ^ a[11];
      3'd6: return a[9] ^ a[17];
      3'd7: return a[9] ^ a[10] ^ a[17];
      default: return 1'b0;
    endcase
  endfunction

  function automatic exp_t model(logic [AW-1:0] a, logic [1:0] t, logic [SW-1:0] s, string tag);
    exp_t e;
    logic [2:0] m;
    e.addr = a; e.tile = 0; e.swz = 0; e.stride = 0; e.fb = 0; e.tag = tag;
    if (t == 2'd1 || t == 2'd2) begin
      m = (t == 2'd1) ? mdl_x : mdl_y;
      if (m == 3'd5) e.fb = 1;
      else begin
        e.addr[6] = a[6] ^ fold_bit(m, a);
        e.tile = t;
        e.stride = s;
        e.swz = (m == 3'd6) ? 3'd1 : (m == 3'd7) ? 3'd2 : m;
      end
    end
    return e;
  endfunction

  task automatic send(logic [AW-1:0] a, logic [1:0] t, logic [SW-1:0] s, string tag,
                      bit with_cfg = 0, bit sel = 0, logic [2:0] code = 0);
    exp_t e;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_tile = t; req_stride = s;
    if (with_cfg) begin cfg_we = 1; cfg_sel = sel; cfg_code = code; end
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    e = model(a, t, s, tag);
    @(posedge clk);
    sb.push_back(e);
    if (with_cfg) begin
      if (sel) mdl_y = code; else mdl_x = code;
    end
    #1 req_valid = 0; cfg_we = 0;
  endtask

  task automatic write_cfg(bit sel, logic [2:0] code);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_code = code;
    @(posedge clk);
    #1 cfg_we = 0;
    if (sel) mdl_y = code; else mdl_x = code;
  endtask

  // back-pressure generator
  always @(negedge clk) res_ready = bp_en ? 1'($urandom % 2) : 1'b1;

  // monitor / scoreboard
  initial begin
    exp_t e;
    bit held = 0;
    logic [AW-1:0] held_addr = 0;
    forever begin
      @(negedge clk); #2;
      if (held) begin
        check(res_valid && res_addr == held_addr, "R9 stall hold", res_addr, held_addr);
        held = 0;
      end
      if (res_valid && !res_ready) begin
        check(!req_ready, "R9 req_ready low while stalled", req_ready, 0);
        held = 1; held_addr = res_addr;
      end
      if (res_valid && res_ready) begin
        if (sb.size() == 0) check(0, "R8 unexpected result", res_addr, 0);
        else begin
          e = sb.pop_front();
          check(res_addr == e.addr, {e.tag, " addr"}, res_addr, e.addr);
          check(res_tile == e.tile && res_swz == e.swz && res_fb_ok(e) &&
                res_stride == e.stride, {e.tag, " tile/swz/stride/fb"},
                {res_tile, res_swz, res_stride, res_fallback},
                {e.tile, e.swz, e.stride, e.fb});
        end
      end
    end
  end

  function automatic bit res_fb_ok(exp_t e);
    return res_fallback == e.fb;
  endfunction

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] pats [8];
    pats = '{32'h0000_0000, 32'h0000_0200, 32'h0000_0400, 32'h0000_0800,
             32'h0002_0000, 32'hFFFF_FFFF, 32'h0002_0E40, 32'h8001_0A3C};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(res_valid == 0, "R1 res_valid after reset", res_valid, 0);
    check(req_ready == 1, "R1 req_ready after reset", req_ready, 1);

    // R1/R7: unconfigured registers force fallback
    send(32'h0000_0E40, 2'd1, 16'h200, "R1 R7 unconfigured X");
    send(32'h0002_0240, 2'd2, 16'h080, "R1 R7 unconfigured Y");

    // R2: linear and reserved layouts ignore the registers
    write_cfg(0, 3'd4);
    write_cfg(1, 3'd7);
    for (int i = 0; i < 8; i++) begin
      send(pats[i], 2'd0, 16'h1234, "R2 linear");
      send(pats[i], 2'd3, 16'h1234, "R2 reserved");
    end

    // R3 R4 R5 R6 R10: every code on both registers
    for (int c = 0; c < 8; c++) begin
      write_cfg(0, 3'(c));
      write_cfg(1, 3'((c + 3) % 8));
      for (int i = 0; i < 8; i++) begin
        send(pats[i], 2'd1, 16'h0400, "R3 R4 R5 R6 R10 X-tiled");
        send(pats[i] ^ 32'h40, 2'd2, 16'h0080, "R3 R4 R5 R6 R7 Y-tiled");
      end
    end

    // R11: write and request at the same edge
    write_cfg(0, 3'd0);
    send(32'h0000_0200, 2'd1, 16'h0200, "R11 same-edge old code", 1, 0, 3'd1);
    send(32'h0000_0200, 2'd1, 16'h0200, "R11 next request new code");

    // R8 R9: random back-pressure
    bp_en = 1;
    write_cfg(1, 3'd2);
    for (int i = 0; i < 200; i++)
      send($urandom, 2'($urandom % 4), 16'($urandom), "R8 R9 back-pressure");
    bp_en = 0;
    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R8 all results delivered", sb.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule